// File: doc/BRIEF.md
# Multi-Lane SPI Transaction Engine

This block is a half-duplex SPI master that carries out one framed transaction at a time with a touch device. Each frame has three parts. First comes an 8-bit command code, then a 24-bit device address, and then a data phase of a host-chosen number of bytes. The host provides the bytes in the data phase of a write. The device returns them in the data phase of a read.

The command code sets both the direction and the data-lane width: one, two or four lines. The engine compares the code with six programmable code inputs to decide this. The command and address bits always go out serially on lane 0. Only the data phase uses the selected width.

The host starts a frame with a one-cycle strobe. It supplies transmit bytes through a byte port paced by a request pulse, and it collects received bytes from a byte port paced by a valid pulse. A done pulse marks the end of each frame. A divider input sets the serial clock rate.

Top module: `mio_spi_engine`

## Requirements
- R1: After reset, chip select (cs_n) is high, sclk is low, io_oe is 0, and done, busy, tx_req and rx_valid are all 0.
- R2: A frame sends the 8-bit command code and then the 24-bit address, 32 bits in all, most significant bit first, on io_out[0] only. During these 32 bits io_oe is 4'b0001.
- R3: The command code is compared with six code inputs. These are single read, single write, dual read, dual write, quad read and quad write, and the values normally loaded are 0x0B, 0x02, 0xBB, 0xB2, 0xEB and 0xE2. Changing an input changes the code that is accepted. A start whose code matches none of the six is ignored: cs_n stays high and done does not pulse.
- R4: In the data phase of a write, each byte goes out most significant bits first. Single mode uses io_out[0] with io_oe=4'b0001. Dual mode uses io_out[1:0], with io_out[1] carrying the higher bit of each pair, and io_oe=4'b0011. Quad mode uses io_out[3:0], with io_out[3] carrying the higher bit of each nibble, and io_oe=4'b1111.
- R5: In the data phase of a read, io_oe is 4'b0000. Bits are sampled on the rising sclk edge. Single mode samples io_in[1]. Dual mode samples io_in[1:0], with io_in[1] as the higher bit. Quad mode samples io_in[3:0], with io_in[3] as the higher bit. Each completed byte appears on rx_data together with a one-cycle rx_valid pulse.
- R6: cs_n stays low for the whole frame. done is high for exactly one clock, in the cycle after cs_n returns high.
- R7: sclk idles low and outputs change only on its falling edges (mode 0). Each sclk high phase and low phase lasts clk_div+1 clock cycles.
- R8: The data phase carries exactly byte_cnt bytes, so the frame has 32 + byte_cnt*8/width rising sclk edges. tx_req pulses once for each transmit byte taken. A byte_cnt of 0 gives a frame with only the command code and address.
- R9: A start strobe that arrives while busy is high is ignored. The frame in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a frame |
| cmd_code | input | 8 | Command code for the frame |
| dev_addr | input | 24 | Device address for the frame |
| byte_cnt | input | CNT_W | Number of data bytes |
| clk_div | input | DIV_W | Number of clock cycles per sclk phase, minus one |
| code_rd1 | input | 8 | Code for a single-lane read |
| code_wr1 | input | 8 | Code for a single-lane write |
| code_rd2 | input | 8 | Code for a dual-lane read |
| code_wr2 | input | 8 | Code for a dual-lane write |
| code_rd4 | input | 8 | Code for a quad-lane read |
| code_wr4 | input | 8 | Code for a quad-lane write |
| tx_data | input | 8 | Next transmit byte; taken when tx_req pulses |
| tx_req | output | 1 | Pulses once for each transmit byte taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Marks rx_data as valid for one cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench covers every combination of the six modes, byte counts of 0, 1 and 3, and divider values of 0 to 2. A model device rebuilds the header and the write bytes from the lanes and supplies read bytes. A design that swaps the lane order inside a nibble or pair, or that sends the header over several lanes, gives bytes that do not match the bench's values. A design that stops one slot too early or too late gives the wrong count of rising edges. A design that drives the lanes during a read shows a nonzero io_oe while the device is sending. The bench also changes a programmed code, sends a code that matches nothing, and strobes start in the middle of a frame. Each of these exposes a design that accepts a stale code or lets the second strobe restart the frame.

// File: rtl/mio_spi_pkg.sv
package mio_spi_pkg;
  typedef enum logic [1:0] {LANE1 = 2'd0, LANE2 = 2'd1, LANE4 = 2'd2} lane_e;
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_TAIL, S_FIN} xfer_st_e;
  localparam int HDR_BITS = 32;
  localparam int NUM_CODES = 6;
endpackage

// File: rtl/mio_spi_decode.sv
module mio_spi_decode
  import mio_spi_pkg::*;
(
  input  logic [7:0] code,
  input  logic [7:0] tbl [NUM_CODES],
  output logic       hit,
  output logic       is_rd,
  output lane_e      lanes
);
  logic [NUM_CODES-1:0] match;
  genvar g;
  generate
    for (g = 0; g < NUM_CODES; g++) begin : g_cmp
      assign match[g] = (code == tbl[g]);
    end
  endgenerate

  // Entry order: rd1, wr1, rd2, wr2, rd4, wr4; lowest index wins.
  always_comb begin
    hit   = |match;
    is_rd = 1'b0;
    lanes = LANE1;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (match[i]) begin
        is_rd = (i % 2) == 0;
        lanes = (i < 2) ? LANE1 : ((i < 4) ? LANE2 : LANE4);
      end
    end
  end
endmodule

// File: rtl/mio_spi_sclk_gen.sv
module mio_spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             gate,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             tick,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);
  assign rise = tick && gate && !sclk;
  assign fall = tick && gate && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      if (gate) sclk <= !sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mio_spi_lane_mux.sv
module mio_spi_lane_mux
  import mio_spi_pkg::*;
(
  input  lane_e       lanes,
  input  logic        load,
  input  logic [7:0]  tx_byte,
  input  logic [7:0]  cur,
  input  logic [3:0]  io_in,
  output logic [7:0]  nxt_byte,
  output logic [3:0]  nxt_bits,
  output logic [7:0]  rx_byte,
  output logic [3:0]  oe_mask,
  output logic [2:0]  slot_last
);
  logic [7:0] shl;

  always_comb begin
    unique case (lanes)
      LANE4: begin
        shl       = {cur[3:0], 4'b0};
        rx_byte   = {cur[3:0], io_in};
        oe_mask   = 4'b1111;
        slot_last = 3'd1;
      end
      LANE2: begin
        shl       = {cur[5:0], 2'b0};
        rx_byte   = {cur[5:0], io_in[1:0]};
        oe_mask   = 4'b0011;
        slot_last = 3'd3;
      end
      default: begin
        shl       = {cur[6:0], 1'b0};
        rx_byte   = {cur[6:0], io_in[1]};
        oe_mask   = 4'b0001;
        slot_last = 3'd7;
      end
    endcase
    nxt_byte = load ? tx_byte : shl;
    unique case (lanes)
      LANE4:   nxt_bits = nxt_byte[7:4];
      LANE2:   nxt_bits = {2'b0, nxt_byte[7:6]};
      default: nxt_bits = {3'b0, nxt_byte[7]};
    endcase
  end
endmodule

// File: rtl/mio_spi_engine.sv
module mio_spi_engine
  import mio_spi_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       cmd_code,
  input  logic [23:0]      dev_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [7:0]       code_rd1,
  input  logic [7:0]       code_wr1,
  input  logic [7:0]       code_rd2,
  input  logic [7:0]       code_wr2,
  input  logic [7:0]       code_rd4,
  input  logic [7:0]       code_wr4,
  input  logic [7:0]       tx_data,
  output logic             tx_req,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int HCNT_W = $clog2(HDR_BITS + 1);

  xfer_st_e          st;
  logic [31:0]       hsh;
  logic [HCNT_W-1:0] hcnt;
  logic [7:0]        dsh;
  logic [2:0]        sc;
  logic [CNT_W-1:0]  rem;
  logic              bdone;
  lane_e             lanes_q;
  logic              rd_q;

  logic [7:0] tbl [NUM_CODES];
  assign tbl[0] = code_rd1;
  assign tbl[1] = code_wr1;
  assign tbl[2] = code_rd2;
  assign tbl[3] = code_wr2;
  assign tbl[4] = code_rd4;
  assign tbl[5] = code_wr4;

  logic  dec_hit, dec_rd;
  lane_e dec_lanes;
  mio_spi_decode u_dec (
    .code(cmd_code), .tbl(tbl), .hit(dec_hit), .is_rd(dec_rd), .lanes(dec_lanes)
  );

  logic run, gate, tick, rise, fall;
  assign run  = (st == S_HDR) || (st == S_DATA) || (st == S_TAIL);
  assign gate = (st != S_TAIL);
  mio_spi_sclk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .gate(gate), .div(clk_div),
    .sclk(sclk), .tick(tick), .rise(rise), .fall(fall)
  );

  logic       ld_tx;
  logic [7:0] nxt_byte, rx_byte;
  logic [3:0] nxt_bits, oe_mask;
  logic [2:0] slot_last;
  assign ld_tx = (st == S_HDR) || bdone;
  mio_spi_lane_mux u_lane (
    .lanes(lanes_q), .load(ld_tx), .tx_byte(tx_data), .cur(dsh), .io_in(io_in),
    .nxt_byte(nxt_byte), .nxt_bits(nxt_bits), .rx_byte(rx_byte),
    .oe_mask(oe_mask), .slot_last(slot_last)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      hsh      <= '0;
      hcnt     <= '0;
      dsh      <= '0;
      sc       <= '0;
      rem      <= '0;
      bdone    <= 1'b0;
      lanes_q  <= LANE1;
      rd_q     <= 1'b0;
      cs_n     <= 1'b1;
      io_out   <= '0;
      io_oe    <= '0;
      tx_req   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      done     <= 1'b0;
    end else begin
      tx_req   <= 1'b0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start && dec_hit) begin
            st      <= S_HDR;
            cs_n    <= 1'b0;
            hsh     <= {cmd_code, dev_addr};
            hcnt    <= '0;
            rem     <= byte_cnt;
            lanes_q <= dec_lanes;
            rd_q    <= dec_rd;
            io_out  <= {3'b0, cmd_code[7]};
            io_oe   <= 4'b0001;
          end
        end
        S_HDR: begin
          if (rise) begin
            hcnt <= hcnt + 1'b1;
          end else if (fall) begin
            if (hcnt == HCNT_W'(HDR_BITS)) begin
              sc    <= '0;
              bdone <= 1'b0;
              if (rem == '0) begin
                st     <= S_TAIL;
                io_out <= '0;
                io_oe  <= '0;
              end else if (rd_q) begin
                st     <= S_DATA;
                io_out <= '0;
                io_oe  <= '0;
              end else begin
                st     <= S_DATA;
                dsh    <= nxt_byte;
                io_out <= nxt_bits;
                io_oe  <= oe_mask;
                tx_req <= 1'b1;
              end
            end else begin
              hsh    <= {hsh[30:0], 1'b0};
              io_out <= {3'b0, hsh[30]};
            end
          end
        end
        S_DATA: begin
          if (rise) begin
            if (rd_q) dsh <= rx_byte;
            if (sc == slot_last) begin
              sc    <= '0;
              rem   <= rem - 1'b1;
              bdone <= 1'b1;
              if (rd_q) begin
                rx_data  <= rx_byte;
                rx_valid <= 1'b1;
              end
            end else begin
              sc    <= sc + 1'b1;
              bdone <= 1'b0;
            end
          end else if (fall) begin
            if (rem == '0 && (rd_q || bdone)) begin
              st     <= S_TAIL;
              io_out <= '0;
              io_oe  <= '0;
            end else if (!rd_q) begin
              dsh    <= nxt_byte;
              io_out <= nxt_bits;
              if (bdone) tx_req <= 1'b1;
            end
            bdone <= 1'b0;
          end
        end
        S_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            st   <= S_FIN;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mio_spi_engine_chk.sv
module mio_spi_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       done,
  input logic       rx_valid,
  input logic       tx_req,
  input logic       busy
);
  a_r6_done_after_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  a_r5_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (io_oe == 4'b0000));
  a_r4_oe_legal: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));
  a_r8_strobes_in_frame: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || tx_req) |-> (!cs_n && busy));
endmodule

bind mio_spi_engine mio_spi_engine_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_oe(io_oe),
  .done(done), .rx_valid(rx_valid), .tx_req(tx_req), .busy(busy)
);

// File: tb/mio_spi_engine_tb.sv
module mio_spi_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int DIV_W = 8;

  logic clk = 0, rst = 1, start = 0;
  logic [7:0] cmd_code = 0;
  logic [23:0] dev_addr = 0;
  logic [CNT_W-1:0] byte_cnt = 0;
  logic [DIV_W-1:0] clk_div = 0;
  logic [7:0] c_rd1 = 8'h0B, c_wr1 = 8'h02, c_rd2 = 8'hBB, c_wr2 = 8'hB2, c_rd4 = 8'hEB, c_wr4 = 8'hE2;
  logic [7:0] tx_data = 0;
  logic tx_req, rx_valid, busy, done, sclk, cs_n;
  logic [7:0] rx_data;
  logic [3:0] io_out, io_oe, io_in;

  mio_spi_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code), .dev_addr(dev_addr),
    .byte_cnt(byte_cnt), .clk_div(clk_div),
    .code_rd1(c_rd1), .code_wr1(c_wr1), .code_rd2(c_rd2), .code_wr2(c_wr2),
    .code_rd4(c_rd4), .code_wr4(c_wr4),
    .tx_data(tx_data), .tx_req(tx_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b, input int seed);
    return 8'((b * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  // Bench-side view of the current frame
  int cur_w = 1, cur_seed = 0;
  bit cur_rd = 0;
  int rises = 0, falls = 0, cs_falls = 0, done_cnt = 0, txreq_cnt = 0, rx_cnt = 0;
  int err_oe = 0, err_hp = 0, err_rx = 0, done_cs_bad = 0, hi = 0;
  logic [31:0] hdr_cap;
  logic [7:0] wr_cap [8];
  int wr_n = 0, slot = 0;
  logic [7:0] acc;

  always @(negedge cs_n) begin
    falls = 0;
    cs_falls++;
  end
  always @(negedge sclk) begin
    if (!cs_n) falls++;
    if (hi != int'(clk_div) + 1) err_hp++;
    hi = 0;
  end

  // Model device read data: slot k after the header
  always_comb begin
    io_in = 4'b0;
    if (cur_rd && falls >= 32) begin
      automatic int k = falls - 32;
      automatic int spb = 8 / cur_w;
      automatic logic [7:0] bv = pat(k / spb, cur_seed);
      automatic logic [7:0] bits = (bv >> (8 - cur_w * ((k % spb) + 1))) & 8'((1 << cur_w) - 1);
      if (cur_w == 1) io_in = {2'b0, bits[0], 1'b0};
      else io_in = bits[3:0];
    end
  end

  always @(posedge sclk) begin
    if (rises < 32) begin
      hdr_cap = {hdr_cap[30:0], io_out[0]};
      if (io_oe != 4'b0001) err_oe++;
    end else if (cur_rd) begin
      if (io_oe != 4'b0000) err_oe++;
    end else begin
      automatic logic [3:0] exp_oe = (cur_w == 4) ? 4'hF : (cur_w == 2) ? 4'h3 : 4'h1;
      if (io_oe != exp_oe) err_oe++;
      acc = 8'((acc << cur_w) | (io_out & 4'((1 << cur_w) - 1)));
      slot++;
      if (slot == 8 / cur_w) begin
        if (wr_n < 8) wr_cap[wr_n] = acc;
        wr_n++;
        slot = 0;
      end
    end
    rises++;
  end

  always @(negedge clk) begin
    if (sclk) hi++;
    if (done) begin
      done_cnt++;
      if (!cs_n) done_cs_bad++;
    end
    if (tx_req) begin
      txreq_cnt++;
      tx_data <= pat(txreq_cnt, cur_seed);
    end
    if (rx_valid) begin
      if (rx_data != pat(rx_cnt, cur_seed)) err_rx++;
      rx_cnt++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic clear_mon(input int w, input bit rd, input int seed);
    cur_w = w; cur_rd = rd; cur_seed = seed;
    rises = 0; done_cnt = 0; txreq_cnt = 0; rx_cnt = 0; cs_falls = 0;
    err_oe = 0; err_hp = 0; err_rx = 0; done_cs_bad = 0;
    wr_n = 0; slot = 0; acc = 0; hdr_cap = 0; hi = 0;
    tx_data = pat(0, seed);
  endtask

  task automatic xfer(input logic [7:0] op, input int w, input bit rd, input int n,
                      input int dv, input int seed, input bit poke);
    @(negedge clk);
    clear_mon(w, rd, seed);
    cmd_code = op; dev_addr = 24'(seed * 4099 + 24'h1A2B3C);
    byte_cnt = CNT_W'(n); clk_div = DIV_W'(dv);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_code = (op == c_wr4) ? c_rd1 : c_wr4;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    begin
      int t = 0;
      while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    end
    repeat (3) @(negedge clk);
    chk(hdr_cap == {op, 24'(seed * 4099 + 24'h1A2B3C)}, "R2 header", hdr_cap, {op, 24'(seed * 4099 + 24'h1A2B3C)});
    chk(err_oe == 0, "R2/R4/R5 lane enables", err_oe, 0);
    chk(rises == 32 + n * 8 / w, "R8 rising edge count", rises, 32 + n * 8 / w);
    chk(done_cnt == 1 && done_cs_bad == 0, "R6 done pulse", done_cnt, 1);
    chk(err_hp == 0, "R7 sclk half period", err_hp, 0);
    if (poke) chk(cs_falls == 1, "R9 start while busy", cs_falls, 1);
    if (rd) begin
      chk(rx_cnt == n && err_rx == 0, "R5 read bytes", err_rx, 0);
    end else begin
      chk(txreq_cnt == n, "R8 tx_req count", txreq_cnt, n);
      for (int b = 0; b < n && b < 8; b++)
        chk(wr_cap[b] == pat(b, seed), "R4 write byte", wr_cap[b], pat(b, seed));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && io_oe == 0, "R1 bus idle", {cs_n, sclk, io_oe}, 6'b100000);
    chk(done == 0 && busy == 0 && tx_req == 0 && rx_valid == 0, "R1 status low",
        {done, busy, tx_req, rx_valid}, 0);

    begin
      int seed = 1;
      for (int m = 0; m < 6; m++) begin
        for (int n = 0; n <= 3; n += (n == 1) ? 2 : 1) begin
          for (int dv = 0; dv < 3; dv++) begin
            automatic int w = (m < 2) ? 1 : (m < 4) ? 2 : 4;
            automatic bit rd = (m % 2) == 0;
            automatic logic [7:0] op = (m == 0) ? c_rd1 : (m == 1) ? c_wr1 : (m == 2) ? c_rd2 :
                                       (m == 3) ? c_wr2 : (m == 4) ? c_rd4 : c_wr4;
            xfer(op, w, rd, n, dv, seed, 1'b0); // R3 default codes
            seed++;
          end
        end
      end
    end

    // R9: second strobe mid-frame
    xfer(c_wr4, 4, 0, 3, 1, 77, 1'b1);
    xfer(c_rd2, 2, 1, 2, 0, 78, 1'b1);

    // R3: unmatched code ignored
    @(negedge clk);
    clear_mon(1, 0, 90);
    cmd_code = 8'h55; start = 1;
    @(negedge clk);
    start = 0;
    repeat (60) @(negedge clk);
    chk(cs_falls == 0 && done_cnt == 0, "R3 unmatched code ignored", cs_falls + done_cnt, 0);

    // R3: reprogrammed single-read code
    c_rd1 = 8'h03;
    xfer(8'h03, 1, 1, 2, 0, 91, 1'b0);
    @(negedge clk);
    clear_mon(1, 1, 92);
    cmd_code = 8'h0B; start = 1;
    @(negedge clk);
    start = 0;
    repeat (60) @(negedge clk);
    chk(cs_falls == 0 && done_cnt == 0, "R3 old code rejected", cs_falls + done_cnt, 0);
    c_rd1 = 8'h0B;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule